// File: doc/BRIEF.md
# Gathering Write-Back Store Buffer

This block sits between a processor's store port and a system bus. It queues stores in a small first-in first-out buffer so the core does not wait on bus latency. Each entry holds one 16-byte quadword together with its quadword address and a per-byte enable mask. Stores marked as accelerated that are smaller than a quadword, and that continue exactly where the previous accelerated store ended inside the same quadword, are folded into the youngest entry. Several such stores then leave as one bus write. Ordinary uncached stores never fold; each one takes an entry of its own.

The core can also raise a barrier request, which is acknowledged only once every buffered store has been handed to the bus. It can also issue an uncached load. The load is held back until the buffer is empty, so the data it returns proves that all earlier writes have retired. The bus side presents quadword writes one at a time with a valid/ready handshake. Reads use a separate request handshake and a response strobe.

Top module: `wb_gather_buf`

## Requirements
- R1: After reset, `st_ready` is 1 and `bw_valid`, `br_valid`, `sync_ack` and `ld_done` are 0.
- R2: Bus writes leave in the same order in which their entries were created by accepted stores.
- R3: A store with `st_accel`=0 always creates its own entry. `st_size` encodes 1, 2, 4, 8 or 16 bytes as 0..4, and the address is naturally aligned. Byte i of a quadword travels on data bits 8i+7:8i. `bw_be` has bit i set exactly for the bytes written, and `bw_data` carries 0 in every byte whose enable is clear.
- R4: An accelerated store whose quadword equals that of the open youngest entry, and whose byte offset equals the end of the bytes gathered so far, merges into that entry. The single bus write then carries the union of the enables.
- R5: An accelerated store that is not sequential (another quadword or another offset) opens a fresh entry. The previously open entry closes.
- R6: An entry whose gathered bytes reach the end of the quadword closes at once and can be issued.
- R7: An open entry with no accepted store for `IDLE_LIMIT` consecutive cycles closes. `bw_valid` for it rises exactly `IDLE_LIMIT` cycles after its last accepted store.
- R8: While all `DEPTH` entries are occupied, `st_ready` is 0. It returns to 1 in the cycle after the bus accepts the oldest entry.
- R9: While `bw_valid` is 1 and `bw_ready` is 0, the write address, data and enables stay unchanged. An entry is removed only in a cycle where `bw_valid` and `bw_ready` are both 1.
- R10: While `sync_req` is 1, `st_ready` is 0 and an open entry closes on the next edge. `sync_ack` is 1 only once the buffer is empty.
- R11: A load raises `br_valid` only after every earlier write has been accepted. `ld_done` pulses with `ld_rdata` equal to `br_rdata` in the cycle `br_rvalid` arrives.
- R12: A merge into the open youngest entry and the bus accepting the oldest entry can happen in the same cycle without losing either effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_accel | input | 1 | Store is accelerated and may gather |
| st_size | input | SIZE_W | Store size code, bytes = 2**code |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | 8*QB | Store data placed on its byte lanes |
| sync_req | input | 1 | Barrier request, held until acknowledged |
| sync_ack | output | 1 | Barrier complete, buffer empty |
| ld_valid | input | 1 | Uncached load request, held until done |
| ld_addr | input | ADDR_W | Load address |
| ld_done | output | 1 | Load data valid this cycle |
| ld_rdata | output | 8*QB | Load data |
| bw_valid | output | 1 | Bus write valid |
| bw_ready | input | 1 | Bus accepts the write |
| bw_addr | output | ADDR_W | Quadword-aligned write address |
| bw_data | output | 8*QB | Write data, disabled bytes zero |
| bw_be | output | QB | Write byte enables |
| br_valid | output | 1 | Bus read request valid |
| br_ready | input | 1 | Bus accepts the read request |
| br_addr | output | ADDR_W | Read address |
| br_rvalid | input | 1 | Read data valid |
| br_rdata | input | 8*QB | Read data |

## Verification
Two functions can fall in one cycle: a sequential accelerated store merges into the open youngest entry while the bus accepts the oldest entry. The bench sets this up by queuing an ordinary store and then opening a gathering entry behind it with the bus stalled. It then raises `bw_ready` in the same cycle as the follow-on accelerated store. The result is judged at the ports. Right after that edge `bw_valid` must be 0, which shows the old entry left and the open one stayed back. The later write must carry the address and the union of both stores' enables.

// File: rtl/wbg_pkg.sv
package wbg_pkg;

  typedef enum logic [1:0] {
    LD_IDLE  = 2'd0,
    LD_DRAIN = 2'd1,
    LD_ADDR  = 2'd2,
    LD_RESP  = 2'd3
  } ld_state_e;

endpackage

// File: rtl/wbg_fifo.sv
module wbg_fifo #(
  parameter int DEPTH = 8,
  parameter int QA_W  = 28,
  parameter int QB    = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_en,
  input  logic [QA_W-1:0]        push_qa,
  input  logic [8*QB-1:0]        push_data,
  input  logic [QB-1:0]          push_be,
  input  logic                   merge_en,
  input  logic [8*QB-1:0]        merge_data,
  input  logic [QB-1:0]          merge_be,
  input  logic                   pop_en,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic [QA_W-1:0]        head_qa_o,
  output logic [8*QB-1:0]        head_data_o,
  output logic [QB-1:0]          head_be_o,
  output logic [QA_W-1:0]        young_qa_o
);

  localparam int DATA_W = 8 * QB;
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic [QA_W-1:0]   qa_mem  [DEPTH];
  logic [DATA_W-1:0] dat_mem [DEPTH];
  logic [QB-1:0]     be_mem  [DEPTH];

  logic [PTR_W-1:0]  wr_q, wr_d, rd_q, rd_d, yng;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] merged_data;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_d  = push_en ? ptr_inc(wr_q) : wr_q;
    rd_d  = pop_en  ? ptr_inc(rd_q) : rd_q;
    cnt_d = cnt_q + CNT_W'(push_en) - CNT_W'(pop_en);
    yng   = (wr_q == '0) ? PTR_W'(DEPTH - 1) : wr_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // byte-lane merge of new store bytes over the youngest entry
  for (genvar b = 0; b < QB; b++) begin : g_merge
    assign merged_data[8*b +: 8] = merge_be[b] ? merge_data[8*b +: 8]
                                               : dat_mem[yng][8*b +: 8];
    assign head_data_o[8*b +: 8] = be_mem[rd_q][b] ? dat_mem[rd_q][8*b +: 8]
                                                   : 8'h00;
  end

  // storage carries no reset: occupancy is tracked by the pointers
  always_ff @(posedge clk) begin
    if (push_en) begin
      qa_mem[wr_q]  <= push_qa;
      dat_mem[wr_q] <= push_data;
      be_mem[wr_q]  <= push_be;
    end else if (merge_en) begin
      dat_mem[yng] <= merged_data;
      be_mem[yng]  <= be_mem[yng] | merge_be;
    end
  end

  assign count_o    = cnt_q;
  assign head_qa_o  = qa_mem[rd_q];
  assign head_be_o  = be_mem[rd_q];
  assign young_qa_o = qa_mem[yng];

endmodule

// File: rtl/wbg_ctrl.sv
module wbg_ctrl #(
  parameter int QA_W       = 28,
  parameter int OFF_W      = 4,
  parameter int SIZE_W     = 3,
  parameter int QB         = 16,
  parameter int IDLE_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_fire,
  input  logic              st_accel,
  input  logic [QA_W-1:0]   st_qa,
  input  logic [OFF_W-1:0]  st_off,
  input  logic [SIZE_W-1:0] st_size,
  input  logic [QA_W-1:0]   young_qa,
  input  logic              flush,
  output logic              push_en,
  output logic              merge_en,
  output logic [QB-1:0]     st_be,
  output logic              open_o
);

  localparam int IW = $clog2(IDLE_LIMIT + 1);

  logic            open_q, open_d;
  logic [OFF_W:0]  nxt_q, nxt_d;
  logic [IW-1:0]   idle_q, idle_d;
  logic [OFF_W:0]  nbytes, end_off;
  logic            hit;

  always_comb begin
    nbytes  = (OFF_W+1)'(1) << st_size;
    end_off = {1'b0, st_off} + nbytes;
    for (int i = 0; i < QB; i++) begin
      st_be[i] = ((OFF_W+1)'(i) >= {1'b0, st_off}) && ((OFF_W+1)'(i) < end_off);
    end
    hit      = open_q && st_accel && (st_qa == young_qa) && ({1'b0, st_off} == nxt_q);
    push_en  = st_fire && !hit;
    merge_en = st_fire && hit;
  end

  always_comb begin
    open_d = open_q;
    nxt_d  = nxt_q;
    idle_d = idle_q;
    if (st_fire) begin
      open_d = st_accel && (end_off != (OFF_W+1)'(QB));
      nxt_d  = end_off;
      idle_d = '0;
    end else if (open_q) begin
      if (flush || (idle_q == IW'(IDLE_LIMIT - 1))) begin
        open_d = 1'b0;
        idle_d = '0;
      end else begin
        idle_d = idle_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      nxt_q  <= '0;
      idle_q <= '0;
    end else begin
      open_q <= open_d;
      nxt_q  <= nxt_d;
      idle_q <= idle_d;
    end
  end

  assign open_o = open_q;

endmodule

// File: rtl/wbg_ld_seq.sv
module wbg_ld_seq #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic              wr_empty,
  input  logic              br_ready,
  input  logic              br_rvalid,
  input  logic [DATA_W-1:0] br_rdata,
  output logic              br_valid,
  output logic [ADDR_W-1:0] br_addr,
  output logic              ld_done,
  output logic [DATA_W-1:0] ld_rdata,
  output logic              busy
);

  import wbg_pkg::*;

  ld_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LD_IDLE:  if (ld_valid)  st_d = LD_DRAIN;
      LD_DRAIN: if (wr_empty)  st_d = LD_ADDR;
      LD_ADDR:  if (br_ready)  st_d = LD_RESP;
      LD_RESP:  if (br_rvalid) st_d = LD_IDLE;
      default:                 st_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= LD_IDLE;
    else        st_q <= st_d;
  end

  assign br_valid = (st_q == LD_ADDR);
  assign br_addr  = ld_addr;
  assign ld_done  = (st_q == LD_RESP) && br_rvalid;
  assign ld_rdata = br_rdata;
  assign busy     = (st_q != LD_IDLE);

endmodule

// File: rtl/wb_gather_buf.sv
module wb_gather_buf #(
  parameter int ADDR_W     = 32,
  parameter int QB         = 16,
  parameter int DEPTH      = 8,
  parameter int SIZE_W     = 3,
  parameter int IDLE_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic              st_accel,
  input  logic [SIZE_W-1:0] st_size,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [8*QB-1:0]   st_data,
  input  logic              sync_req,
  output logic              sync_ack,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_done,
  output logic [8*QB-1:0]   ld_rdata,
  output logic              bw_valid,
  input  logic              bw_ready,
  output logic [ADDR_W-1:0] bw_addr,
  output logic [8*QB-1:0]   bw_data,
  output logic [QB-1:0]     bw_be,
  output logic              br_valid,
  input  logic              br_ready,
  output logic [ADDR_W-1:0] br_addr,
  input  logic              br_rvalid,
  input  logic [8*QB-1:0]   br_rdata
);

  localparam int DATA_W = 8 * QB;
  localparam int OFF_W  = $clog2(QB);
  localparam int QA_W   = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(DEPTH + 1);

  logic              st_fire, push_en, merge_en, open_flag, ld_busy, flush, pop_en;
  logic [QB-1:0]     st_be;
  logic [CNT_W-1:0]  wr_count;
  logic [QA_W-1:0]   head_qa, young_qa, st_qa;
  logic [OFF_W-1:0]  st_off;

  assign st_qa    = st_addr[ADDR_W-1:OFF_W];
  assign st_off   = st_addr[OFF_W-1:0];
  assign flush    = sync_req || ld_valid;
  assign st_ready = (wr_count != CNT_W'(DEPTH)) && !flush && !ld_busy;
  assign st_fire  = st_valid && st_ready;

  // the open youngest entry is held back until it closes
  assign bw_valid = (wr_count != '0) && !(open_flag && (wr_count == CNT_W'(1)));
  assign pop_en   = bw_valid && bw_ready;
  assign bw_addr  = {head_qa, {OFF_W{1'b0}}};
  assign sync_ack = sync_req && (wr_count == '0);

  wbg_ctrl #(
    .QA_W(QA_W), .OFF_W(OFF_W), .SIZE_W(SIZE_W), .QB(QB), .IDLE_LIMIT(IDLE_LIMIT)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_fire  (st_fire),
    .st_accel (st_accel),
    .st_qa    (st_qa),
    .st_off   (st_off),
    .st_size  (st_size),
    .young_qa (young_qa),
    .flush    (flush),
    .push_en  (push_en),
    .merge_en (merge_en),
    .st_be    (st_be),
    .open_o   (open_flag)
  );

  wbg_fifo #(
    .DEPTH(DEPTH), .QA_W(QA_W), .QB(QB)
  ) u_fifo (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_en     (push_en),
    .push_qa     (st_qa),
    .push_data   (st_data),
    .push_be     (st_be),
    .merge_en    (merge_en),
    .merge_data  (st_data),
    .merge_be    (st_be),
    .pop_en      (pop_en),
    .count_o     (wr_count),
    .head_qa_o   (head_qa),
    .head_data_o (bw_data),
    .head_be_o   (bw_be),
    .young_qa_o  (young_qa)
  );

  wbg_ld_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_ld (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_valid  (ld_valid),
    .ld_addr   (ld_addr),
    .wr_empty  (wr_count == '0),
    .br_ready  (br_ready),
    .br_rvalid (br_rvalid),
    .br_rdata  (br_rdata),
    .br_valid  (br_valid),
    .br_addr   (br_addr),
    .ld_done   (ld_done),
    .ld_rdata  (ld_rdata),
    .busy      (ld_busy)
  );

endmodule

// File: rtl/wbg_chk.sv
module wbg_chk #(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 32,
  parameter int QB     = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_ready,
  input logic [CNT_W-1:0]  wr_count,
  input logic              bw_valid,
  input logic              bw_ready,
  input logic [ADDR_W-1:0] bw_addr,
  input logic [8*QB-1:0]   bw_data,
  input logic [QB-1:0]     bw_be,
  input logic              br_valid,
  input logic              sync_req,
  input logic              sync_ack
);

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_count == CNT_W'(DEPTH)) |-> !st_ready); // R8

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_valid && !bw_ready) |=> (bw_valid && $stable(bw_addr) && $stable(bw_be) && $stable(bw_data))); // R9

  AST_RD_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid |-> !bw_valid); // R11

  AST_SYNC_BLOCKS_ST: assert property (@(posedge clk) disable iff (!rst_n)
    sync_req |-> !st_ready); // R10

  AST_ACK_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ack |-> !bw_valid); // R10

  AST_BE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    bw_valid |-> (bw_be != '0)); // R3

endmodule

bind wb_gather_buf wbg_chk #(
  .DEPTH(DEPTH), .CNT_W($clog2(DEPTH + 1)), .ADDR_W(ADDR_W), .QB(QB)
) u_wbg_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .st_ready (st_ready),
  .wr_count (wr_count),
  .bw_valid (bw_valid),
  .bw_ready (bw_ready),
  .bw_addr  (bw_addr),
  .bw_data  (bw_data),
  .bw_be    (bw_be),
  .br_valid (br_valid),
  .sync_req (sync_req),
  .sync_ack (sync_ack)
);

// File: tb/test_wb_gather_buf.sv
module test_wb_gather_buf;

  localparam int ADDR_W     = 32;
  localparam int QB         = 16;
  localparam int DEPTH      = 8;
  localparam int SIZE_W     = 3;
  localparam int IDLE_LIMIT = 4;
  localparam int DATA_W     = 8 * QB;

  logic              clk, rst_n;
  logic              st_valid, st_ready, st_accel;
  logic [SIZE_W-1:0] st_size;
  logic [ADDR_W-1:0] st_addr;
  logic [DATA_W-1:0] st_data;
  logic              sync_req, sync_ack;
  logic              ld_valid, ld_done;
  logic [ADDR_W-1:0] ld_addr;
  logic [DATA_W-1:0] ld_rdata;
  logic              bw_valid, bw_ready;
  logic [ADDR_W-1:0] bw_addr;
  logic [DATA_W-1:0] bw_data;
  logic [QB-1:0]     bw_be;
  logic              br_valid, br_ready, br_rvalid;
  logic [ADDR_W-1:0] br_addr;
  logic [DATA_W-1:0] br_rdata;

  int n_tests = 0;
  int n_fail  = 0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  wb_gather_buf #(
    .ADDR_W(ADDR_W), .QB(QB), .DEPTH(DEPTH), .SIZE_W(SIZE_W), .IDLE_LIMIT(IDLE_LIMIT)
  ) i_wb_gather_buf (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_ready(st_ready), .st_accel(st_accel),
    .st_size(st_size), .st_addr(st_addr), .st_data(st_data),
    .sync_req(sync_req), .sync_ack(sync_ack),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_done(ld_done), .ld_rdata(ld_rdata),
    .bw_valid(bw_valid), .bw_ready(bw_ready), .bw_addr(bw_addr),
    .bw_data(bw_data), .bw_be(bw_be),
    .br_valid(br_valid), .br_ready(br_ready), .br_addr(br_addr),
    .br_rvalid(br_rvalid), .br_rdata(br_rdata)
  );

  // stimulus table: {accel, size code, byte address}
  localparam logic [35:0] ST_VEC [8] = '{
    {1'b0, 3'd2, 32'h0000_0100},
    {1'b1, 3'd2, 32'h0000_0200},
    {1'b1, 3'd2, 32'h0000_0204},
    {1'b1, 3'd3, 32'h0000_0208},
    {1'b1, 3'd2, 32'h0000_0210},
    {1'b1, 3'd0, 32'h0000_0218},
    {1'b0, 3'd1, 32'h0000_021A},
    {1'b1, 3'd4, 32'h0000_0300}
  };
  // expected bus writes: {quadword address, byte enables}
  localparam logic [47:0] WR_EXP [6] = '{
    {32'h0000_0100, 16'h000F},
    {32'h0000_0200, 16'hFFFF},
    {32'h0000_0210, 16'h000F},
    {32'h0000_0210, 16'h0100},
    {32'h0000_0210, 16'h0C00},
    {32'h0000_0300, 16'hFFFF}
  };

  function automatic logic [7:0] pat(input logic [ADDR_W-1:0] a);
    return a[7:0] ^ 8'h3C;
  endfunction

  function automatic logic [QB-1:0] mask_of(input logic [3:0] off, input logic [2:0] sz);
    logic [QB-1:0] m;
    for (int i = 0; i < QB; i++) m[i] = (i >= int'(off)) && (i < int'(off) + (1 << sz));
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] exp_data(input logic [ADDR_W-1:0] qa, input logic [QB-1:0] be);
    logic [DATA_W-1:0] d;
    for (int i = 0; i < QB; i++) d[8*i +: 8] = be[i] ? pat(qa + ADDR_W'(i)) : 8'h00;
    return d;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [DATA_W-1:0] act,
                     input logic [DATA_W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic store(input bit accel, input logic [2:0] sz, input logic [ADDR_W-1:0] a);
    logic [QB-1:0] m;
    logic r;
    m = mask_of(a[3:0], sz);
    for (int i = 0; i < QB; i++)
      st_data[8*i +: 8] = m[i] ? pat({a[ADDR_W-1:4], 4'(i)}) : 8'hEE;
    st_accel = accel;
    st_size  = sz;
    st_addr  = a;
    st_valid = 1'b1;
    forever begin
      #1 r = st_ready;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  // called and returns at a falling edge; pops exactly one write
  task automatic get_write(output logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                           output logic [QB-1:0] be);
    a = '0; d = '0; be = '0;
    bw_ready = 1'b1;
    for (int k = 0; k < 200; k++) begin
      #1;
      if (bw_valid) begin
        a = bw_addr; d = bw_data; be = bw_be;
        @(posedge clk);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    bw_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog all-requirements act=hung exp=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [ADDR_W-1:0] wa;
    logic [DATA_W-1:0] wd;
    logic [QB-1:0]     wbe;
    int zeros;
    bit both;

    rst_n = 1'b0; st_valid = 1'b0; st_accel = 1'b0; st_size = '0; st_addr = '0; st_data = '0;
    sync_req = 1'b0; ld_valid = 1'b0; ld_addr = '0; bw_ready = 1'b0;
    br_ready = 1'b1; br_rvalid = 1'b0; br_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(st_ready && !bw_valid && !br_valid && !sync_ack && !ld_done, "R1 reset outputs",
        {st_ready, bw_valid, br_valid, sync_ack, ld_done}, 5'b10000);
    @(negedge clk);

    // table walk: queue with the bus stalled, then drain and compare
    for (int v = 0; v < 8; v++) store(ST_VEC[v][35], ST_VEC[v][34:32], ST_VEC[v][31:0]);
    for (int w = 0; w < 6; w++) begin
      get_write(wa, wd, wbe);
      chk(wa == WR_EXP[w][47:16] && wbe == WR_EXP[w][15:0] &&
          wd == exp_data(WR_EXP[w][47:16], WR_EXP[w][15:0]),
          $sformatf("R2/R3/R4/R5/R6 table write %0d", w),
          {wa, wbe}, {WR_EXP[w][47:16], WR_EXP[w][15:0]});
    end

    // R7: idle timeout closes an open gathering entry
    store(1'b1, 3'd2, 32'h0000_0400);
    zeros = 0;
    for (int j = 0; j < 50; j++) begin
      #1;
      if (bw_valid) break;
      zeros++;
      @(negedge clk);
    end
    chk(zeros == IDLE_LIMIT, "R7 cycles before timeout issue", DATA_W'(zeros), DATA_W'(IDLE_LIMIT));
    get_write(wa, wd, wbe);
    chk(wa == 32'h400 && wbe == 16'h000F, "R7 timed-out entry", {wa, wbe}, {32'h400, 16'h000F});

    // R8 / R9: full buffer stalls the core, head holds until accepted
    for (int k = 0; k < DEPTH; k++) store(1'b0, 3'd4, 32'h0000_1000 + 32'(16 * k));
    #1;
    chk(!st_ready, "R8 full stalls store port", DATA_W'(st_ready), '0);
    repeat (2) @(negedge clk);
    #1;
    chk(bw_valid && bw_addr == 32'h1000, "R9 head held while stalled", DATA_W'(bw_addr), DATA_W'(32'h1000));
    bw_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bw_ready = 1'b0;
    #1;
    chk(st_ready, "R8 ready returns after accept", DATA_W'(st_ready), DATA_W'(1));
    chk(bw_addr == 32'h1010, "R9 removal only on accept", DATA_W'(bw_addr), DATA_W'(32'h1010));
    @(negedge clk);
    for (int k = 1; k < DEPTH; k++) begin
      get_write(wa, wd, wbe);
      chk(wa == 32'h0000_1000 + 32'(16 * k) && wbe == 16'hFFFF, "R2 drain order",
          DATA_W'(wa), DATA_W'(32'h0000_1000 + 32'(16 * k)));
    end

    // R12: merge into the youngest while the oldest is accepted
    store(1'b0, 3'd3, 32'h0000_0500);
    store(1'b1, 3'd2, 32'h0000_0600);
    bw_ready = 1'b1;
    store(1'b1, 3'd2, 32'h0000_0604);
    bw_ready = 1'b0;
    #1;
    chk(!bw_valid, "R12 oldest left, open entry held", DATA_W'(bw_valid), '0);
    get_write(wa, wd, wbe);
    chk(wa == 32'h600 && wbe == 16'h00FF && wd == exp_data(32'h600, 16'h00FF),
        "R12 merged entry", {wa, wbe}, {32'h600, 16'h00FF});

    // R10: barrier closes the open entry and waits for the drain
    store(1'b1, 3'd2, 32'h0000_0700);
    sync_req = 1'b1;
    #1;
    chk(!st_ready && !sync_ack, "R10 barrier blocks stores", {st_ready, sync_ack}, '0);
    @(negedge clk);
    #1;
    chk(bw_valid && !sync_ack, "R10 open entry closed, no ack yet", {bw_valid, sync_ack}, 2'b10);
    @(negedge clk);
    get_write(wa, wd, wbe);
    #1;
    chk(sync_ack && wa == 32'h700 && wbe == 16'h000F, "R10 ack after drain",
        {sync_ack, wa, wbe}, {1'b1, 32'h700, 16'h000F});
    sync_req = 1'b0;
    @(negedge clk);

    // R11: load waits for buffered writes, then returns bus data
    store(1'b0, 3'd2, 32'h0000_0900);
    store(1'b0, 3'd2, 32'h0000_0910);
    ld_addr  = 32'h0000_0800;
    ld_valid = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(!br_valid, "R11 no read while writes pending", DATA_W'(br_valid), '0);
    bw_ready = 1'b1;
    both = 1'b0;
    for (int j = 0; j < 50; j++) begin
      @(negedge clk);
      #1;
      if (bw_valid && br_valid) both = 1'b1;
      if (br_valid) break;
    end
    bw_ready = 1'b0;
    chk(br_valid && !both && br_addr == 32'h800, "R11 read after drain",
        {br_valid, both, br_addr}, {2'b10, 32'h800});
    @(negedge clk);
    br_rdata  = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
    br_rvalid = 1'b1;
    #1;
    chk(ld_done && ld_rdata == br_rdata, "R11 load data", ld_rdata, br_rdata);
    ld_valid = 1'b0;
    @(negedge clk);
    br_rvalid = 1'b0;
    #1;
    chk(!ld_done && st_ready && !bw_valid, "R1 idle after load", {ld_done, st_ready, bw_valid}, 3'b010);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule